// File: doc/BRIEF.md
# DDR Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DDR SDRAM. It moves the memory into self refresh on request and later brings it back to normal operation. When an entry request is accepted, the block drives one refresh command with clock enable low. It then keeps clock enable low until a wake request arrives.

The wake path runs as a fixed script. Clock enable rises only after the clock-stable input is seen high. A window of no-operation cycles covers the exit-recovery time. A mode-register write with the DLL-reset bit set follows, and then a second padding window of no-operations. A one-cycle ready pulse tells the rest of the controller that ordinary commands may be issued again.

All command, address and clock-enable outputs come from registers. Each output therefore appears in the cycle after the edge that decided it.

Top module: `srSeqTop`

## Requirements
- R1: While reset is held, and in the first cycle after it, clock enable is high, the command is NOP ({csN,rasN,casN,weN} = 4'b0111), the address is zero, and enterAck, exitAck and ready are low.
- R2: An enterReq sampled high in the idle state produces, in the next cycle, exactly one refresh command (4'b0001) with clock enable low. enterAck is high in that same cycle only.
- R3: After entry, clock enable stays low and the command is NOP until an exit request has been accepted and clkStable has been sampled high.
- R4: Clock enable rises in the cycle after the first edge, following exit acceptance, at which clkStable is high. If clkStable is already high at the edge after the acceptance edge, clock enable rises one cycle after exitAck.
- R5: Once clock enable has risen, exactly XSNR_CYC cycles of NOP with clock enable high are driven, counting the rise cycle, before the mode-register write.
- R6: The DLL-reset write is command 4'b0000 with bank 2'b00 and address MODE_BASE with bit DLL_RST_BIT set. With the defaults, MODE_BASE = 13'h022 and DLL_RST_BIT = 8, so the address is 13'h122. It lasts one cycle.
- R7: After the write, exactly DLL_WAIT_CYC NOP cycles follow. Then ready is high for exactly one cycle, with NOP and clock enable high. After that the block is idle again and accepts a new entry request.
- R8: enterReq has no effect in any state other than idle. No refresh command is driven, enterAck stays low, and clock enable is unchanged.
- R9: exitReq has no effect in any state other than self refresh. In idle, clock enable stays high and exitAck stays low.
- R10: exitAck is high for exactly one cycle: the cycle after the edge that accepted the exit request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterReq | input | 1 | Request to enter self refresh |
| exitReq | input | 1 | Request to leave self refresh |
| clkStable | input | 1 | Memory clock reported stable |
| enterAck | output | 1 | One-cycle acknowledge, entry accepted |
| exitAck | output | 1 | One-cycle acknowledge, exit accepted |
| ready | output | 1 | One-cycle pulse, normal commands may resume |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, used for mode-register selection |
| addr | output | ADDR_W | Address bus, carries the mode value during the DLL-reset write |

## Verification
The assertions assume the following about the inputs. clkStable may be sampled at any time, but it only matters while the block waits to raise clock enable. Requests are level inputs that may be held or repeated in any state. The stimulus drives every input shortly after a rising edge and holds it for a whole cycle, so no sample lands on a changing value. The stimulus also deliberately holds requests high in states where they must be ignored, and it keeps clkStable low for several cycles after an exit request, so the gate on clock enable is exercised both ways.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_IN_SR,
    ST_WAIT_CLK,
    ST_XSNR_WAIT,
    ST_DLL_RST,
    ST_DLL_WAIT,
    ST_READY
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic issueSre;   // drive refresh with clock enable low
    logic raiseCke;   // raise clock enable and load exit-recovery count
    logic issueMrs;   // drive DLL-reset mode write
    logic loadDll;    // load post-reset padding count
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/srSeqCtrl.sv
module srSeqCtrl
  import srseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       exitReq,
  input  logic       clkStable,
  input  logic       cntZero,
  output seqState_t  state,
  output seqStrobe_t strobe,
  output logic       enterAck,
  output logic       exitAck,
  output logic       ready
);

  seqState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (enterReq) begin
        stateNext       = ST_ENTER;
        strobe.issueSre = 1'b1;
      end
      ST_ENTER:    stateNext = ST_IN_SR;
      ST_IN_SR:    if (exitReq) stateNext = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clkStable) begin
        stateNext       = ST_XSNR_WAIT;
        strobe.raiseCke = 1'b1;
      end
      ST_XSNR_WAIT: if (cntZero) begin
        stateNext       = ST_DLL_RST;
        strobe.issueMrs = 1'b1;
      end
      ST_DLL_RST: begin
        stateNext      = ST_DLL_WAIT;
        strobe.loadDll = 1'b1;
      end
      ST_DLL_WAIT: if (cntZero) stateNext = ST_READY;
      ST_READY:    stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enterAck <= 1'b0;
      exitAck  <= 1'b0;
    end else begin
      state    <= stateNext;
      enterAck <= (state == ST_IDLE) && enterReq;
      exitAck  <= (state == ST_IN_SR) && exitReq;
    end
  end

  assign ready = (state == ST_READY);

  // R8: entry state is only reached from idle
  assert_enter_from_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTER) |-> ($past(state) == ST_IDLE));

  // R9: the wait-for-clock state is first entered only from self refresh with a request
  assert_exit_from_sr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_CLK && $past(state) != ST_WAIT_CLK) |-> $past(state == ST_IN_SR && exitReq));

  // R10: exit acknowledge is a single-cycle pulse
  assert_exit_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    exitAck |=> !exitAck);

  // R7: ready is a single-cycle pulse followed by idle
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> (!ready && state == ST_IDLE));

endmodule

// File: rtl/srSeqDp.sv
module srSeqDp
  import srseq_pkg::*;
#(
  parameter int              ADDR_W       = 13,
  parameter int              XSNR_CYC     = 200,
  parameter int              DLL_WAIT_CYC = 200,
  parameter logic [ADDR_W-1:0] MODE_BASE  = 13'h022,
  parameter int              DLL_RST_BIT  = 8,
  parameter logic [1:0]      MRS_BANK     = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              cntZero,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int CNT_MAX = (XSNR_CYC > DLL_WAIT_CYC) ? XSNR_CYC : DLL_WAIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  XSNR_LOAD = CNT_W'(XSNR_CYC - 1);
  localparam logic [CNT_W-1:0]  DLL_LOAD  = CNT_W'(DLL_WAIT_CYC - 1);
  localparam logic [ADDR_W-1:0] MRS_ADDR  = MODE_BASE | (ADDR_W'(1) << DLL_RST_BIT);

  logic [CNT_W-1:0] cnt;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.raiseCke) begin
      cnt <= XSNR_LOAD;
    end else if (strobe.loadDll) begin
      cnt <= DLL_LOAD;
    end else if (!cntZero) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke  <= 1'b1;
      cmd  <= CMD_NOP;
      ba   <= 2'b00;
      addr <= '0;
    end else begin
      if (strobe.issueSre)      cke <= 1'b0;
      else if (strobe.raiseCke) cke <= 1'b1;
      if (strobe.issueSre)      cmd <= CMD_REF;
      else if (strobe.issueMrs) cmd <= CMD_MRS;
      else                      cmd <= CMD_NOP;
      ba   <= strobe.issueMrs ? MRS_BANK : 2'b00;
      addr <= strobe.issueMrs ? MRS_ADDR : '0;
    end
  end

  // R5: a mode write only follows an expired exit-recovery count
  assert_mrs_after_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MRS) |-> $past(cntZero));

  // R2: refresh is always driven with clock enable low
  assert_ref_cke_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF) |-> !cke);

endmodule

// File: rtl/srSeqTop.sv
module srSeqTop
  import srseq_pkg::*;
#(
  parameter int                ADDR_W       = 13,
  parameter int                XSNR_CYC     = 200,
  parameter int                DLL_WAIT_CYC = 200,
  parameter logic [ADDR_W-1:0] MODE_BASE    = 13'h022,
  parameter int                DLL_RST_BIT  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic              clkStable,
  output logic              enterAck,
  output logic              exitAck,
  output logic              ready,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);

  seqState_t  state;
  seqStrobe_t strobe;
  logic       cntZero;
  logic [3:0] cmd;

  srSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .clkStable(clkStable), .cntZero(cntZero), .state(state), .strobe(strobe),
    .enterAck(enterAck), .exitAck(exitAck), .ready(ready)
  );

  srSeqDp #(
    .ADDR_W(ADDR_W), .XSNR_CYC(XSNR_CYC), .DLL_WAIT_CYC(DLL_WAIT_CYC),
    .MODE_BASE(MODE_BASE), .DLL_RST_BIT(DLL_RST_BIT), .MRS_BANK(2'b00)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntZero(cntZero),
    .cke(cke), .cmd(cmd), .ba(ba), .addr(addr)
  );

  assign {csN, rasN, casN, weN} = cmd;

  // R3: clock enable stays low throughout self refresh
  assert_sr_cke_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IN_SR || state == ST_WAIT_CLK) |-> (!cke && cmd == CMD_NOP));

  // R4: clock enable rises only after the clock was reported stable
  assert_cke_rise_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> $past(clkStable));

  // R7: ready coincides with NOP and clock enable high
  assert_ready_nop_R7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cke && cmd == CMD_NOP));

  // R8: handshake pulses never overlap
  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enterAck, exitAck, ready}));

endmodule

// File: tb/tb_srSeqTop.sv
`timescale 1ns/100ps
module tb_srSeqTop;

  localparam int XSNR = 200;
  localparam int DLLW = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enterReq = 1'b0, exitReq = 1'b0, clkStable = 1'b0;
  logic enterAck, exitAck, ready, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [12:0] addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  srSeqTop dut (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .clkStable(clkStable), .enterAck(enterAck), .exitAck(exitAck),
    .ready(ready), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr)
  );

  wire [3:0] cmd = {csN, rasN, casN, weN};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {enterReq, exitReq, clkStable, expCke, expCmd[3:0], expEnterAck, expExitAck}
  localparam logic [9:0] VEC [9] = '{
    10'b0_1_0_1_0111_0_0,  // R9 exit ignored in idle
    10'b1_0_0_0_0001_1_0,  // R2 entry
    10'b1_0_0_0_0111_0_0,  // R8 held entry ignored
    10'b0_0_0_0_0111_0_0,  // R3 in self refresh
    10'b0_0_1_0_0111_0_0,  // R3 stable clock alone does nothing
    10'b0_1_0_0_0111_0_1,  // R10 exit accepted
    10'b0_1_0_0_0111_0_0,  // R10 ack drops, R3 cke low
    10'b1_0_0_0_0111_0_0,  // R8 entry ignored while waiting
    10'b0_0_1_1_0111_0_0   // R4 clock stable raises cke
  };
  localparam int VREQ [9] = '{9, 2, 8, 3, 3, 10, 10, 8, 4};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk(cke == 1'b1 && cmd == 4'b0111, "R1 reset outputs", {cke, cmd}, 5'h17);
    chk({enterAck, exitAck, ready} == 3'b000 && addr == 13'h0, "R1 reset pulses", {enterAck, exitAck, ready}, 0);
    rstN = 1'b1;
    step();
    chk(cke == 1'b1 && cmd == 4'b0111, "R1 after release", {cke, cmd}, 5'h17);

    for (int i = 0; i < 9; i++) begin
      {enterReq, exitReq, clkStable} = VEC[i][9:7];
      step();
      chk({cke, cmd, enterAck, exitAck} == VEC[i][6:0],
          $sformatf("R%0d vector %0d", VREQ[i], i), {cke, cmd, enterAck, exitAck}, VEC[i][6:0]);
    end
    {enterReq, exitReq, clkStable} = 3'b000;

    // R5 exit-recovery window; R8 entry toggled and ignored
    for (int k = 1; k < XSNR; k++) begin
      enterReq = k[0];
      step();
      chk(cke && cmd == 4'b0111 && !enterAck, "R5 R8 nop window", {cke, cmd, enterAck}, 6'h2E);
    end
    enterReq = 1'b0;
    step();
    chk(cke && cmd == 4'b0000, "R5 mode write cycle", {cke, cmd}, 5'h10);
    chk(ba == 2'b00 && addr == 13'h122, "R6 mode write address", {ba, addr}, 15'h0122);

    // R7 padding window and ready pulse
    for (int j = 1; j <= DLLW; j++) begin
      step();
      chk(cke && cmd == 4'b0111 && !ready && addr == 13'h0, "R7 padding nop", {cke, cmd, ready}, 6'h2E);
    end
    step();
    chk(ready && cke && cmd == 4'b0111, "R7 ready pulse", {ready, cke, cmd}, 6'h37);
    step();
    chk(!ready && cke, "R7 ready one cycle", {ready, cke}, 1);
    enterReq = 1'b1;
    step();
    chk(cmd == 4'b0001 && !cke && enterAck, "R7 R2 re-entry after ready", {cmd, cke, enterAck}, 6'h05);
    enterReq = 1'b0;
    step();
    chk(!cke && !enterAck, "R2 enter ack one cycle", {cke, enterAck}, 0);

    // R4 clock already stable at exit
    clkStable = 1'b1;
    exitReq = 1'b1;
    step();
    exitReq = 1'b0;
    chk(exitAck && !cke, "R10 exit ack", {exitAck, cke}, 2);
    step();
    chk(cke && !exitAck, "R4 immediate cke rise", {cke, exitAck}, 2);

    // R1 reset mid-sequence
    rstN = 1'b0;
    step();
    chk(cke && cmd == 4'b0111 && !ready && !exitAck, "R1 mid-run reset", {cke, cmd}, 5'h17);
    rstN = 1'b1;
    clkStable = 1'b0;
    step();
    chk(cke && cmd == 4'b0111, "R1 idle after reset", {cke, cmd}, 5'h17);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule